// File: doc/BRIEF.md
# Scalar Accumulator ALU with Carry and Zero Flags

This block is the arithmetic core of a small accumulator-style scalar unit. It holds three 32-bit working registers (A, X and Y) together with a carry flag and a zero flag. Each accepted command is either an ALU command or a flag command.

An ALU command carries a 4-bit operation code and three 2-bit selectors: one for the destination and one for each of the two sources. Code 00 on the first-source selector gives the constant zero. Code 00 on the second-source selector gives a zero-extended 16-bit immediate. Code 00 on the destination selector discards the result but still updates the flags, which gives compare-style operations. A flag command forces carry, zero or both to given values.

Most operations complete at the clock edge that accepts them. The multiply is iterative. It runs one shift-add step per cycle, and `cmd_ready` stays low until the product has been written.

The control is a three-state machine:
- `ST_IDLE` accepts commands. It stays in `ST_IDLE` for every single-cycle command and moves to `ST_MULT` when it accepts a multiply.
- `ST_MULT` performs one step per cycle. It stays in `ST_MULT` until the last step, then moves to `ST_DONE`.
- `ST_DONE` writes the product and the flags, then returns to `ST_IDLE`.

Top module: `scalar_acc_alu`

## Requirements
- R1: After reset, A, X, Y, carry and zero are all 0 and `cmd_ready` is 1.
- R2: Destination code 00 writes no register, and 01, 10, 11 write A, X, Y. First-source code 00 gives 0 and second-source code 00 gives `imm` zero-extended to 32 bits. Codes 01, 10, 11 on either source give A, X, Y.
- R3: ADD (0000) gives s1+s2, ADC (0001) gives s1+s2+carry and INC (0100) gives s1+1. Carry takes the carry-out of bit 31.
- R4: SUB (0010) gives s1-s2, SBC (0011) gives s1-s2-carry and DEC (0110) gives s1-1. Carry is set when the subtraction borrows.
- R5: AND (1000), OR (1001) and XOR (1010) combine s1 and s2 bitwise and leave carry unchanged.
- R6: Each shift moves s1 by one bit, and carry takes the bit shifted out.
  - LSL (1100) and LSR (1110) insert 0.
  - ROL (1101) and ROR (1111) insert the old carry.
- R7: Every ALU command with a known code sets zero exactly when the 32-bit result is 0. This holds even when the destination is 00, and in that case A, X and Y keep their values.
- R8: Operation codes 0101 and 0111 change no register and no flag.
- R9: MUL (1011) writes the low 32 bits of s1*s2. Carry is set when the high 32 bits are nonzero, and zero is set when the low half is 0. `cmd_ready` is low for exactly 33 cycles after the accepting edge.
- R10: A flag command (`cmd_is_flag`=1) does the following:
  - It loads carry from `flag_val[0]` when `flag_sel[0]` is 1, and zero from `flag_val[1]` when `flag_sel[1]` is 1.
  - It leaves unselected flags and all registers unchanged.
- R11: Commands presented while `cmd_ready` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_is_flag | input | 1 | 1: flag command, 0: ALU command |
| op_code | input | 4 | ALU operation code |
| dst_sel | input | 2 | Destination selector |
| src1_sel | input | 2 | First-source selector |
| src2_sel | input | 2 | Second-source selector |
| imm | input | 16 | Immediate for second source |
| flag_sel | input | 2 | Flag-command mask (bit0 carry, bit1 zero) |
| flag_val | input | 2 | Flag-command values (bit0 carry, bit1 zero) |
| reg_a | output | 32 | Register A |
| reg_x | output | 32 | Register X |
| reg_y | output | 32 | Register Y |
| carry | output | 1 | Carry flag |
| zero | output | 1 | Zero flag |

## Verification
Each operation is driven with operands chosen to tell apart the cases that share an output:
- All-ones plus one separates carry-out from a plain sum.
- Zero minus one separates borrow from a plain difference.
- A rotate with carry set separates rotates from logical shifts.
- An immediate of 0xFFFF exposes sign extension.

The multiplier is tried with a small product and with 0x10000 squared. The second case leaves the low half zero and the high half nonzero, which tells the carry and zero rules apart. The remaining cases are:
- Destination-none compares, unused codes and flag masks, which show what is left untouched.
- Commands held during a multiply, which show that nothing is accepted while busy.

// File: rtl/sacc_pkg.sv
package sacc_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'b0000,
        OP_ADC = 4'b0001,
        OP_SUB = 4'b0010,
        OP_SBC = 4'b0011,
        OP_INC = 4'b0100,
        OP_DEC = 4'b0110,
        OP_AND = 4'b1000,
        OP_OR  = 4'b1001,
        OP_XOR = 4'b1010,
        OP_MUL = 4'b1011,
        OP_LSL = 4'b1100,
        OP_ROL = 4'b1101,
        OP_LSR = 4'b1110,
        OP_ROR = 4'b1111
    } alu_op_e;

    typedef enum logic [1:0] {
        SEL_ALT = 2'b00,
        SEL_A   = 2'b01,
        SEL_X   = 2'b10,
        SEL_Y   = 2'b11
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_MULT = 2'b01,
        ST_DONE = 2'b10
    } seq_state_e;

endpackage

// File: rtl/sacc_operand_sel.sv
module sacc_operand_sel
    import sacc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [1:0]      sel,
    input  logic [XLEN-1:0] alt_val,
    input  logic [XLEN-1:0] a_val,
    input  logic [XLEN-1:0] x_val,
    input  logic [XLEN-1:0] y_val,
    output logic [XLEN-1:0] operand
);

    always_comb begin
        unique case (reg_sel_e'(sel))
            SEL_A:   operand = a_val;
            SEL_X:   operand = x_val;
            SEL_Y:   operand = y_val;
            default: operand = alt_val;
        endcase
    end

endmodule

// File: rtl/sacc_datapath.sv
module sacc_datapath
    import sacc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [3:0]      op_code,
    input  logic [XLEN-1:0] src1,
    input  logic [XLEN-1:0] src2,
    input  logic            carry_in,
    output logic [XLEN-1:0] result,
    output logic            carry_out,
    output logic            carry_we,
    output logic            op_known,
    output logic            op_is_mul
);

    localparam logic [XLEN-1:0] ONE_W = XLEN'(1);

    logic [XLEN-1:0] add_b;
    logic [XLEN-1:0] sub_b;
    logic            add_ci;
    logic            sub_bi;
    logic [XLEN:0]   sum_ext;
    logic [XLEN:0]   diff_ext;
    alu_op_e         op;

    assign op = alu_op_e'(op_code);

    always_comb begin
        add_b    = (op == OP_INC) ? ONE_W : src2;
        add_ci   = (op == OP_ADC) ? carry_in : 1'b0;
        sub_b    = (op == OP_DEC) ? ONE_W : src2;
        sub_bi   = (op == OP_SBC) ? carry_in : 1'b0;
        sum_ext  = {1'b0, src1} + {1'b0, add_b} + {{XLEN{1'b0}}, add_ci};
        diff_ext = {1'b0, src1} - {1'b0, sub_b} - {{XLEN{1'b0}}, sub_bi};
    end

    always_comb begin
        result    = '0;
        carry_out = carry_in;
        carry_we  = 1'b0;
        op_known  = 1'b1;
        op_is_mul = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC, OP_INC: begin
                result    = sum_ext[XLEN-1:0];
                carry_out = sum_ext[XLEN];
                carry_we  = 1'b1;
            end
            OP_SUB, OP_SBC, OP_DEC: begin
                result    = diff_ext[XLEN-1:0];
                carry_out = diff_ext[XLEN];
                carry_we  = 1'b1;
            end
            OP_AND: result = src1 & src2;
            OP_OR:  result = src1 | src2;
            OP_XOR: result = src1 ^ src2;
            OP_MUL: op_is_mul = 1'b1;
            OP_LSL: begin
                result    = {src1[XLEN-2:0], 1'b0};
                carry_out = src1[XLEN-1];
                carry_we  = 1'b1;
            end
            OP_ROL: begin
                result    = {src1[XLEN-2:0], carry_in};
                carry_out = src1[XLEN-1];
                carry_we  = 1'b1;
            end
            OP_LSR: begin
                result    = {1'b0, src1[XLEN-1:1]};
                carry_out = src1[0];
                carry_we  = 1'b1;
            end
            OP_ROR: begin
                result    = {carry_in, src1[XLEN-1:1]};
                carry_out = src1[0];
                carry_we  = 1'b1;
            end
            default: op_known = 1'b0;
        endcase
    end

endmodule

// File: rtl/sacc_iter_mul.sv
module sacc_iter_mul #(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              step,
    input  logic [XLEN-1:0]   op_a,
    input  logic [XLEN-1:0]   op_b,
    output logic              last_step,
    output logic [2*XLEN-1:0] product
);

    localparam int CNT_W = $clog2(XLEN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(XLEN - 1);

    logic [2*XLEN-1:0] mcand_q;
    logic [XLEN-1:0]   mplier_q;
    logic [2*XLEN-1:0] acc_q;
    logic [CNT_W-1:0]  cnt_q;

    assign last_step = step && (cnt_q == CNT_LAST);
    assign product   = acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            acc_q    <= '0;
            cnt_q    <= '0;
        end else if (start) begin
            mcand_q  <= {{XLEN{1'b0}}, op_a};
            mplier_q <= op_b;
            acc_q    <= '0;
            cnt_q    <= '0;
        end else if (step) begin
            if (mplier_q[0]) begin
                acc_q <= acc_q + mcand_q;
            end
            mcand_q  <= {mcand_q[2*XLEN-2:0], 1'b0};
            mplier_q <= {1'b0, mplier_q[XLEN-1:1]};
            cnt_q    <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/scalar_acc_alu.sv
module scalar_acc_alu
    import sacc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_is_flag,
    input  logic [3:0]       op_code,
    input  logic [1:0]       dst_sel,
    input  logic [1:0]       src1_sel,
    input  logic [1:0]       src2_sel,
    input  logic [IMM_W-1:0] imm,
    input  logic [1:0]       flag_sel,
    input  logic [1:0]       flag_val,
    output logic [XLEN-1:0]  reg_a,
    output logic [XLEN-1:0]  reg_x,
    output logic [XLEN-1:0]  reg_y,
    output logic             carry,
    output logic             zero
);

    localparam int PROD_W = 2 * XLEN;

    seq_state_e        state_q;
    seq_state_e        state_d;
    logic [XLEN-1:0]   a_q;
    logic [XLEN-1:0]   x_q;
    logic [XLEN-1:0]   y_q;
    logic              c_q;
    logic              z_q;
    logic [1:0]        dst_hold_q;

    logic [XLEN-1:0]   imm_ext;
    logic [XLEN-1:0]   src1;
    logic [XLEN-1:0]   src2;
    logic [XLEN-1:0]   dp_result;
    logic              dp_carry;
    logic              dp_carry_we;
    logic              dp_known;
    logic              dp_is_mul;
    logic [PROD_W-1:0] product;
    logic              mul_last;

    logic              accept;
    logic              mul_start;
    logic              mul_step;
    logic              wb_en;
    logic [1:0]        wb_dst;
    logic [XLEN-1:0]   wb_data;
    logic              c_we;
    logic              c_d;
    logic              z_we;
    logic              z_d;

    assign imm_ext = {{(XLEN-IMM_W){1'b0}}, imm};
    assign accept  = cmd_valid && (state_q == ST_IDLE);

    sacc_operand_sel #(.XLEN(XLEN)) u_src1 (
        .sel     (src1_sel),
        .alt_val ('0),
        .a_val   (a_q),
        .x_val   (x_q),
        .y_val   (y_q),
        .operand (src1)
    );

    sacc_operand_sel #(.XLEN(XLEN)) u_src2 (
        .sel     (src2_sel),
        .alt_val (imm_ext),
        .a_val   (a_q),
        .x_val   (x_q),
        .y_val   (y_q),
        .operand (src2)
    );

    sacc_datapath #(.XLEN(XLEN)) u_dp (
        .op_code   (op_code),
        .src1      (src1),
        .src2      (src2),
        .carry_in  (c_q),
        .result    (dp_result),
        .carry_out (dp_carry),
        .carry_we  (dp_carry_we),
        .op_known  (dp_known),
        .op_is_mul (dp_is_mul)
    );

    sacc_iter_mul #(.XLEN(XLEN)) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (mul_start),
        .step      (mul_step),
        .op_a      (src1),
        .op_b      (src2),
        .last_step (mul_last),
        .product   (product)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && !cmd_is_flag && dp_is_mul) state_d = ST_MULT;
            ST_MULT: if (mul_last) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output and write-back decisions per state
    always_comb begin
        cmd_ready = 1'b0;
        mul_start = 1'b0;
        mul_step  = 1'b0;
        wb_en     = 1'b0;
        wb_dst    = dst_sel;
        wb_data   = dp_result;
        c_we      = 1'b0;
        c_d       = c_q;
        z_we      = 1'b0;
        z_d       = z_q;
        unique case (state_q)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                if (accept) begin
                    if (cmd_is_flag) begin
                        c_we = flag_sel[0];
                        c_d  = flag_val[0];
                        z_we = flag_sel[1];
                        z_d  = flag_val[1];
                    end else if (dp_is_mul) begin
                        mul_start = 1'b1;
                    end else if (dp_known) begin
                        wb_en = (dst_sel != SEL_ALT);
                        c_we  = dp_carry_we;
                        c_d   = dp_carry;
                        z_we  = 1'b1;
                        z_d   = (dp_result == '0);
                    end
                end
            end
            ST_MULT: begin
                mul_step = 1'b1;
            end
            ST_DONE: begin
                wb_dst  = dst_hold_q;
                wb_en   = (dst_hold_q != SEL_ALT);
                wb_data = product[XLEN-1:0];
                c_we    = 1'b1;
                c_d     = (product[PROD_W-1:XLEN] != '0);
                z_we    = 1'b1;
                z_d     = (product[XLEN-1:0] == '0);
            end
            default: ;
        endcase
    end

    // Register file, flags and held destination
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q        <= '0;
            x_q        <= '0;
            y_q        <= '0;
            c_q        <= 1'b0;
            z_q        <= 1'b0;
            dst_hold_q <= SEL_ALT;
        end else begin
            if (mul_start) dst_hold_q <= dst_sel;
            if (wb_en) begin
                unique case (reg_sel_e'(wb_dst))
                    SEL_A:   a_q <= wb_data;
                    SEL_X:   x_q <= wb_data;
                    SEL_Y:   y_q <= wb_data;
                    default: ;
                endcase
            end
            if (c_we) c_q <= c_d;
            if (z_we) z_q <= z_d;
        end
    end

    assign reg_a = a_q;
    assign reg_x = x_q;
    assign reg_y = y_q;
    assign carry = c_q;
    assign zero  = z_q;

endmodule

// File: rtl/sacc_checker.sv
module sacc_checker #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             cmd_is_flag,
    input logic [3:0]       op_code,
    input logic [1:0]       dst_sel,
    input logic [1:0]       flag_sel,
    input logic [1:0]       flag_val,
    input logic [XLEN-1:0]  reg_a,
    input logic [XLEN-1:0]  reg_x,
    input logic [XLEN-1:0]  reg_y,
    input logic             carry,
    input logic             zero
);

    logic acc;
    assign acc = cmd_valid && cmd_ready;

    // R7
    add_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !cmd_is_flag && op_code == 4'b0000 && dst_sel == 2'b01)
        |=> (zero == (reg_a == '0)));

    // R8
    unused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !cmd_is_flag && (op_code == 4'b0101 || op_code == 4'b0111))
        |=> ($stable(reg_a) && $stable(reg_x) && $stable(reg_y)
             && $stable(carry) && $stable(zero)));

    // R5
    logic_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !cmd_is_flag && op_code[3:2] == 2'b10 && op_code[1:0] != 2'b11)
        |=> $stable(carry));

    // R10
    flag_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_is_flag)
        |=> ($stable(reg_a) && $stable(reg_x) && $stable(reg_y)));

    // R10
    flag_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_is_flag && flag_sel[0])
        |=> (carry == $past(flag_val[0])));

    // R9
    mul_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !cmd_is_flag && op_code == 4'b1011)
        |=> !cmd_ready);

    // R7
    none_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !cmd_is_flag && dst_sel == 2'b00 && op_code != 4'b1011)
        |=> ($stable(reg_a) && $stable(reg_x) && $stable(reg_y)));

endmodule

bind scalar_acc_alu sacc_checker #(.XLEN(XLEN), .IMM_W(IMM_W)) u_sacc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_is_flag (cmd_is_flag),
    .op_code     (op_code),
    .dst_sel     (dst_sel),
    .flag_sel    (flag_sel),
    .flag_val    (flag_val),
    .reg_a       (reg_a),
    .reg_x       (reg_x),
    .reg_y       (reg_y),
    .carry       (carry),
    .zero        (zero)
);

// File: tb/tb_scalar_acc_alu.sv
`timescale 1ns/1ps
module tb_scalar_acc_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_is_flag = 1'b0;
    logic [3:0]  op_code = '0;
    logic [1:0]  dst_sel = '0;
    logic [1:0]  src1_sel = '0;
    logic [1:0]  src2_sel = '0;
    logic [15:0] imm = '0;
    logic [1:0]  flag_sel = '0;
    logic [1:0]  flag_val = '0;
    logic [31:0] reg_a, reg_x, reg_y;
    logic        carry, zero;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_a = '0, m_x = '0, m_y = '0;
    logic        m_c = 1'b0, m_z = 1'b0;

    always #2 clk = ~clk;

    scalar_acc_alu dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_is_flag(cmd_is_flag), .op_code(op_code), .dst_sel(dst_sel),
        .src1_sel(src1_sel), .src2_sel(src2_sel), .imm(imm),
        .flag_sel(flag_sel), .flag_val(flag_val),
        .reg_a(reg_a), .reg_x(reg_x), .reg_y(reg_y), .carry(carry), .zero(zero)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got 0x%08h expected 0x%08h", tag, what, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "A", reg_a, m_a);
        check(tag, "X", reg_x, m_x);
        check(tag, "Y", reg_y, m_y);
        check(tag, "carry", {31'b0, carry}, {31'b0, m_c});
        check(tag, "zero", {31'b0, zero}, {31'b0, m_z});
        check(tag, "ready", {31'b0, cmd_ready}, 32'd1);
    endtask

    function automatic logic [31:0] pick(input logic [1:0] s, input logic [31:0] alt);
        case (s)
            2'b01:   return m_a;
            2'b10:   return m_x;
            2'b11:   return m_y;
            default: return alt;
        endcase
    endfunction

    task automatic model_alu(input logic [3:0] op, input logic [1:0] d,
                             input logic [1:0] s1s, input logic [1:0] s2s,
                             input logic [15:0] im);
        logic [31:0] s1, s2, r;
        logic [32:0] t;
        logic [63:0] p;
        logic        c, kn;
        s1 = pick(s1s, 32'h0);
        s2 = pick(s2s, {16'h0, im});
        c  = m_c;
        kn = 1'b1;
        r  = '0;
        case (op)
            4'b0000: begin t = {1'b0, s1} + {1'b0, s2}; r = t[31:0]; c = t[32]; end
            4'b0001: begin t = {1'b0, s1} + {1'b0, s2} + {32'b0, m_c}; r = t[31:0]; c = t[32]; end
            4'b0100: begin t = {1'b0, s1} + 33'd1; r = t[31:0]; c = t[32]; end
            4'b0010: begin t = {1'b0, s1} - {1'b0, s2}; r = t[31:0]; c = t[32]; end
            4'b0011: begin t = {1'b0, s1} - {1'b0, s2} - {32'b0, m_c}; r = t[31:0]; c = t[32]; end
            4'b0110: begin t = {1'b0, s1} - 33'd1; r = t[31:0]; c = t[32]; end
            4'b1000: r = s1 & s2;
            4'b1001: r = s1 | s2;
            4'b1010: r = s1 ^ s2;
            4'b1011: begin p = {32'b0, s1} * {32'b0, s2}; r = p[31:0]; c = (p[63:32] != 0); end
            4'b1100: begin r = s1 << 1; c = s1[31]; end
            4'b1101: begin r = {s1[30:0], m_c}; c = s1[31]; end
            4'b1110: begin r = s1 >> 1; c = s1[0]; end
            4'b1111: begin r = {m_c, s1[31:1]}; c = s1[0]; end
            default: kn = 1'b0;
        endcase
        if (kn) begin
            m_c = c;
            m_z = (r == 0);
            case (d)
                2'b01: m_a = r;
                2'b10: m_x = r;
                2'b11: m_y = r;
                default: ;
            endcase
        end
    endtask

    // Issues one ALU command, waits for completion, returns cycles with ready low
    task automatic alu(input logic [3:0] op, input logic [1:0] d, input logic [1:0] s1,
                       input logic [1:0] s2, input logic [15:0] im, output int busy);
        @(negedge clk);
        cmd_is_flag = 1'b0; op_code = op; dst_sel = d;
        src1_sel = s1; src2_sel = s2; imm = im; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        busy = 0;
        while (!cmd_ready && busy < 1000) begin
            @(negedge clk);
            busy++;
        end
        model_alu(op, d, s1, s2, im);
    endtask

    task automatic flagcmd(input logic [1:0] sel, input logic [1:0] val);
        @(negedge clk);
        cmd_is_flag = 1'b1; flag_sel = sel; flag_val = val; op_code = 4'b0000;
        dst_sel = 2'b01; src1_sel = 2'b01; src2_sel = 2'b00; imm = 16'h0;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_is_flag = 1'b0;
        if (sel[0]) m_c = val[0];
        if (sel[1]) m_z = val[1];
    endtask

    task automatic t_reset();
        check_all("R1");
    endtask

    task automatic t_select();
        int b;
        alu(4'b0000, 2'b01, 2'b00, 2'b00, 16'h1234, b); check_all("R2");
        alu(4'b0000, 2'b10, 2'b01, 2'b00, 16'hFFFF, b); check_all("R2");
        check("R2", "zext", reg_x, 32'h0001_1233);
        alu(4'b0000, 2'b11, 2'b10, 2'b01, 16'h0, b); check_all("R2");
        alu(4'b1001, 2'b01, 2'b11, 2'b10, 16'h0, b); check_all("R2");
    endtask

    task automatic t_add();
        int b;
        alu(4'b0000, 2'b01, 2'b00, 2'b00, 16'h0, b);
        alu(4'b0110, 2'b01, 2'b01, 2'b00, 16'h0, b); check_all("R4");
        alu(4'b0000, 2'b10, 2'b01, 2'b00, 16'h0001, b); check_all("R3");
        alu(4'b0001, 2'b11, 2'b00, 2'b00, 16'h0005, b); check_all("R3");
        check("R3", "adc", reg_y, 32'h6);
        alu(4'b0100, 2'b01, 2'b01, 2'b00, 16'h0, b); check_all("R3");
        alu(4'b0100, 2'b10, 2'b11, 2'b00, 16'h0, b); check_all("R3");
    endtask

    task automatic t_sub();
        int b;
        alu(4'b0010, 2'b10, 2'b00, 2'b00, 16'h0001, b); check_all("R4");
        alu(4'b0011, 2'b11, 2'b10, 2'b00, 16'h0010, b); check_all("R4");
        check("R4", "sbc", reg_y, 32'hFFFF_FFEE);
        alu(4'b0011, 2'b01, 2'b11, 2'b00, 16'h0001, b); check_all("R4");
        alu(4'b0110, 2'b01, 2'b00, 2'b00, 16'h0, b); check_all("R4");
    endtask

    task automatic t_logic();
        int b;
        flagcmd(2'b01, 2'b01);
        alu(4'b1000, 2'b10, 2'b01, 2'b00, 16'hF0F0, b); check_all("R5");
        alu(4'b1010, 2'b11, 2'b10, 2'b00, 16'hFFFF, b); check_all("R5");
        flagcmd(2'b01, 2'b00);
        alu(4'b1001, 2'b01, 2'b00, 2'b00, 16'h0, b); check_all("R5");
    endtask

    task automatic t_shift();
        int b;
        alu(4'b0000, 2'b01, 2'b00, 2'b00, 16'h0001, b);
        flagcmd(2'b01, 2'b01);
        alu(4'b1111, 2'b01, 2'b01, 2'b00, 16'h0, b); check_all("R6");
        check("R6", "ror", reg_a, 32'h8000_0000);
        alu(4'b1101, 2'b10, 2'b01, 2'b00, 16'h0, b); check_all("R6");
        alu(4'b1100, 2'b11, 2'b01, 2'b00, 16'h0, b); check_all("R6");
        alu(4'b1110, 2'b01, 2'b01, 2'b00, 16'h0, b); check_all("R6");
        flagcmd(2'b01, 2'b01);
        alu(4'b1110, 2'b10, 2'b00, 2'b00, 16'h0, b); check_all("R6");
    endtask

    task automatic t_none();
        int b;
        alu(4'b0010, 2'b00, 2'b01, 2'b01, 16'h0, b); check_all("R7");
        alu(4'b0000, 2'b00, 2'b00, 2'b00, 16'h0042, b); check_all("R7");
    endtask

    task automatic t_unused();
        int b;
        flagcmd(2'b11, 2'b11);
        alu(4'b0101, 2'b01, 2'b00, 2'b00, 16'h0099, b); check_all("R8");
        flagcmd(2'b11, 2'b00);
        alu(4'b0111, 2'b10, 2'b00, 2'b00, 16'h0000, b); check_all("R8");
    endtask

    task automatic t_mul();
        int b;
        alu(4'b0000, 2'b10, 2'b00, 2'b00, 16'h0007, b);
        alu(4'b0000, 2'b11, 2'b00, 2'b00, 16'h0006, b);
        alu(4'b1011, 2'b01, 2'b10, 2'b11, 16'h0, b); check_all("R9");
        check("R9", "busy cycles", b, 33);
        alu(4'b0000, 2'b10, 2'b00, 2'b00, 16'h0001, b);
        alu(4'b1100, 2'b10, 2'b10, 2'b00, 16'h0, b);
        for (int i = 0; i < 15; i++) alu(4'b1100, 2'b10, 2'b10, 2'b00, 16'h0, b);
        alu(4'b1011, 2'b11, 2'b10, 2'b10, 16'h0, b); check_all("R9");
        alu(4'b1011, 2'b00, 2'b10, 2'b00, 16'h0003, b); check_all("R9");
    endtask

    task automatic t_flags();
        flagcmd(2'b01, 2'b01); check_all("R10");
        flagcmd(2'b10, 2'b10); check_all("R10");
        flagcmd(2'b01, 2'b10); check_all("R10");
        flagcmd(2'b10, 2'b01); check_all("R10");
        flagcmd(2'b00, 2'b11); check_all("R10");
        flagcmd(2'b11, 2'b11); check_all("R10");
    endtask

    task automatic t_busy();
        int b;
        alu(4'b0000, 2'b01, 2'b00, 2'b00, 16'h0009, b);
        @(negedge clk);
        cmd_is_flag = 1'b0; op_code = 4'b1011; dst_sel = 2'b01;
        src1_sel = 2'b01; src2_sel = 2'b00; imm = 16'h0003; cmd_valid = 1'b1;
        @(negedge clk);
        op_code = 4'b0000; dst_sel = 2'b10; src1_sel = 2'b00; imm = 16'h5555;
        for (int i = 0; i < 10; i++) @(negedge clk);
        cmd_is_flag = 1'b1; flag_sel = 2'b11; flag_val = 2'b11;
        for (int i = 0; i < 5; i++) @(negedge clk);
        cmd_valid = 1'b0; cmd_is_flag = 1'b0;
        b = 0;
        while (!cmd_ready && b < 1000) begin @(negedge clk); b++; end
        model_alu(4'b1011, 2'b01, 2'b01, 2'b00, 16'h0003);
        check_all("R11");
        check("R11", "product", reg_a, 32'd27);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_select();
        t_add();
        t_sub();
        t_logic();
        t_shift();
        t_none();
        t_unused();
        t_mul();
        t_flags();
        t_busy();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule